// File: doc/BRIEF.md
# Residue Number System Arithmetic Unit

This block adds, subtracts or multiplies two integers that are held in residue form. Each operand is a packed word of four residue digits, one per modulus of the coprime set {5, 7, 9, 4}. Each digit lane works alone: no carry, borrow or partial product crosses from one lane to another. The moduli multiply to 1260, so every result is the true integer result reduced modulo 1260 and then written again in residue form.

A subtract complements each digit of the second operand against its own lane modulus and then runs the lane adder. A zero digit complements to zero, not to the modulus. The result and a valid flag are registered, so a result appears one clock after the operands are accepted. A small combinational helper module turns a binary integer into the packed residue word. Turning residues back into a weighted value, sign detection and division are not part of the block.

Top module: `rns_alu`

## Requirements
- R1: Packed residue words put the mod-5 digit in bits [2:0], the mod-7 digit in bits [5:3], the mod-9 digit in bits [9:6] and the mod-4 digit in bits [11:10]. Every input digit is below its lane modulus.
- R2: With opcode 2'b00 (add), each result digit is (a + b) mod m for that lane's modulus m.
- R3: With opcode 2'b01 (subtract), each result digit is (a + c) mod m, where c = m − b for b ≠ 0 and c = 0 for b = 0. This equals (a − b) mod m.
- R4: With opcode 2'b10 (multiply), each result digit is (a · b) mod m.
- R5: A change to the operand digits of one lane changes only that lane's result digit.
- R6: When `in_valid` is high with a legal opcode, `out_valid` is high on the next cycle and `y_res` holds the result. Back-to-back operations give back-to-back results. `out_valid` is low in any cycle that does not follow such an accepted operation.
- R7: Opcode 2'b11 is reserved. An operation carrying it raises no `out_valid`, and `y_res` keeps its previous value.
- R8: While `rst_n` is low, `out_valid` and `y_res` are zero.
- R9: Every digit of `y_res` is below its lane modulus whenever `out_valid` is high.
- R10: Results match integer arithmetic modulo 1260. Examples: 29 + 27 gives the residues of 56, 10 · 17 gives the residues of 170, and 10 − 17 gives the residues of 1253.
- R11: The helper `rns_bin2res` maps a binary input v to the packed word of (v mod m) digits in the R1 layout, for any input width including values at and above 1260.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and opcode are valid this cycle |
| opcode | input | 2 | 00 add, 01 subtract, 10 multiply, 11 reserved |
| a_res | input | 12 | First operand, packed residue digits |
| b_res | input | 12 | Second operand, packed residue digits |
| out_valid | output | 1 | Result valid, one cycle after an accepted operation |
| y_res | output | 12 | Registered packed residue result |

## Verification
The bench checks subtraction where subtrahend digits are zero. A design that complemented zero to the modulus itself would put an out-of-range digit such as 5 or 9 in the result. It drives operand pairs that differ in one lane only and watches for results that change in other lanes, which would mean a carry leaks between lanes. It also checks sums and products that wrap past 1260, where an error shows up as a wrong residue in the lane whose reduction fails. Finally, it sends reserved-opcode operations between legal ones. A design that did not drop them would raise a stray `out_valid` or overwrite the held result.

// File: rtl/rns_pkg.sv
package rns_pkg;

   typedef enum logic [1:0] {
      RNS_ADD = 2'b00,
      RNS_SUB = 2'b01,
      RNS_MUL = 2'b10,
      RNS_RSV = 2'b11
   } rns_op_e;

   localparam int unsigned NUM_LANES = 4;

   // digit width needed to hold values 0 .. m-1
   function automatic int unsigned digit_width(input int unsigned m);
      return (m <= 2) ? 1 : $clog2(m);
   endfunction

   function automatic int unsigned gcd_u(input int unsigned x, input int unsigned y);
      int unsigned p;
      int unsigned q;
      int unsigned t;
      p = x;
      q = y;
      for (int k = 0; k < 64; k++) begin
         if (q != 0) begin
            t = p % q;
            p = q;
            q = t;
         end
      end
      return p;
   endfunction

   function automatic int unsigned pick_mod(input int unsigned idx,
                                            input int unsigned m0, input int unsigned m1,
                                            input int unsigned m2, input int unsigned m3);
      case (idx)
         0: return m0;
         1: return m1;
         2: return m2;
         default: return m3;
      endcase
   endfunction

   // low bit position of lane idx inside the packed residue word
   function automatic int unsigned field_lo(input int unsigned idx,
                                            input int unsigned m0, input int unsigned m1,
                                            input int unsigned m2, input int unsigned m3);
      int unsigned acc;
      acc = 0;
      for (int unsigned k = 0; k < NUM_LANES; k++) begin
         if (k < idx) acc += digit_width(pick_mod(k, m0, m1, m2, m3));
      end
      return acc;
   endfunction

endpackage

// File: rtl/rns_mod_add.sv
module rns_mod_add #(
   parameter int unsigned MOD = 5,
   parameter int unsigned W   = 3
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] y
);
   localparam logic [W:0] MODX = (W+1)'(MOD);

   logic [W:0] sum;

   always_comb begin
      sum = {1'b0, a} + {1'b0, b};
      if (sum >= MODX) y = W'(sum - MODX);
      else             y = sum[W-1:0];
   end
endmodule

// File: rtl/rns_mod_mul.sv
module rns_mod_mul #(
   parameter int unsigned MOD = 5,
   parameter int unsigned W   = 3
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] y
);
   localparam int unsigned PW = 2 * W;
   localparam logic [PW-1:0] MODP = PW'(MOD);

   logic [PW-1:0] prod;
   logic [PW-1:0] rem;

   always_comb begin
      prod = PW'(a) * PW'(b);
      rem  = prod % MODP;
      y    = rem[W-1:0];
   end
endmodule

// File: rtl/rns_lane.sv
module rns_lane
   import rns_pkg::*;
#(
   parameter int unsigned MOD = 5,
   parameter int unsigned W   = 3
) (
   input  rns_op_e      op,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] y
);
   localparam logic [W-1:0] MODW = W'(MOD);

   logic [W-1:0] b_comp;
   logic [W-1:0] addend;
   logic [W-1:0] sum_y;
   logic [W-1:0] mul_y;

   // complement against lane modulus, zero maps to zero
   always_comb begin
      if (b == '0) b_comp = '0;
      else         b_comp = MODW - b;
      addend = (op == RNS_SUB) ? b_comp : b;
   end

   rns_mod_add #(.MOD(MOD), .W(W)) u_add (
      .a(a),
      .b(addend),
      .y(sum_y)
   );

   rns_mod_mul #(.MOD(MOD), .W(W)) u_mul (
      .a(a),
      .b(b),
      .y(mul_y)
   );

   always_comb begin
      y = (op == RNS_MUL) ? mul_y : sum_y;
   end
endmodule

// File: rtl/rns_bin2res.sv
module rns_bin2res
   import rns_pkg::*;
#(
   parameter int unsigned BW    = 16,
   parameter int unsigned MOD_A = 5,
   parameter int unsigned MOD_B = 7,
   parameter int unsigned MOD_C = 9,
   parameter int unsigned MOD_D = 4,
   localparam int unsigned RW = digit_width(MOD_A) + digit_width(MOD_B)
                              + digit_width(MOD_C) + digit_width(MOD_D)
) (
   input  logic [BW-1:0] bin_val,
   output logic [RW-1:0] res_val
);
   if (BW < 2) begin : g_bad_bw
      $error("rns_bin2res: BW must be at least 2");
   end

   for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
      localparam int unsigned LM = pick_mod(i, MOD_A, MOD_B, MOD_C, MOD_D);
      localparam int unsigned LW = digit_width(LM);
      localparam int unsigned LO = field_lo(i, MOD_A, MOD_B, MOD_C, MOD_D);
      localparam int unsigned XW = (BW > LW) ? BW : LW;
      logic [XW-1:0] rem;
      always_comb rem = XW'(bin_val) % XW'(LM);
      assign res_val[LO +: LW] = rem[LW-1:0];
   end
endmodule

// File: rtl/rns_alu.sv
module rns_alu
   import rns_pkg::*;
#(
   parameter int unsigned MOD_A = 5,
   parameter int unsigned MOD_B = 7,
   parameter int unsigned MOD_C = 9,
   parameter int unsigned MOD_D = 4,
   localparam int unsigned RW = digit_width(MOD_A) + digit_width(MOD_B)
                              + digit_width(MOD_C) + digit_width(MOD_D)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [1:0]    opcode,
   input  logic [RW-1:0] a_res,
   input  logic [RW-1:0] b_res,
   output logic          out_valid,
   output logic [RW-1:0] y_res
);
   // elaboration-time parameter checks
   if (MOD_A < 2 || MOD_B < 2 || MOD_C < 2 || MOD_D < 2) begin : g_bad_mod
      $error("rns_alu: every modulus must be at least 2");
   end
   if (gcd_u(MOD_A, MOD_B) != 1 || gcd_u(MOD_A, MOD_C) != 1 || gcd_u(MOD_A, MOD_D) != 1 ||
       gcd_u(MOD_B, MOD_C) != 1 || gcd_u(MOD_B, MOD_D) != 1 || gcd_u(MOD_C, MOD_D) != 1)
   begin : g_not_coprime
      $error("rns_alu: moduli must be pairwise coprime");
   end

   rns_op_e       op;
   logic          legal;
   logic [RW-1:0] lane_y;

   always_comb begin
      op    = rns_op_e'(opcode);
      legal = (op != RNS_RSV);
   end

   for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
      localparam int unsigned LM = pick_mod(i, MOD_A, MOD_B, MOD_C, MOD_D);
      localparam int unsigned LW = digit_width(LM);
      localparam int unsigned LO = field_lo(i, MOD_A, MOD_B, MOD_C, MOD_D);
      rns_lane #(.MOD(LM), .W(LW)) u_lane (
         .op(op),
         .a (a_res[LO +: LW]),
         .b (b_res[LO +: LW]),
         .y (lane_y[LO +: LW])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         y_res     <= '0;
      end else begin
         out_valid <= in_valid && legal;
         if (in_valid && legal) y_res <= lane_y;
      end
   end
endmodule

// File: rtl/rns_alu_chk.sv
module rns_alu_chk
   import rns_pkg::*;
#(
   parameter int unsigned MOD_A = 5,
   parameter int unsigned MOD_B = 7,
   parameter int unsigned MOD_C = 9,
   parameter int unsigned MOD_D = 4,
   localparam int unsigned RW = digit_width(MOD_A) + digit_width(MOD_B)
                              + digit_width(MOD_C) + digit_width(MOD_D)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_valid,
   input logic [1:0]    opcode,
   input logic [RW-1:0] a_res,
   input logic [RW-1:0] b_res,
   input logic          out_valid,
   input logic [RW-1:0] y_res
);
   p_issue_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && opcode != 2'b11) |=> out_valid);

   p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_valid && opcode != 2'b11) |=> !out_valid);

   p_reserved_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && opcode == 2'b11) |=> (!out_valid && $stable(y_res)));

   p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(y_res));

   for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
      localparam int unsigned LM = pick_mod(i, MOD_A, MOD_B, MOD_C, MOD_D);
      localparam int unsigned LW = digit_width(LM);
      localparam int unsigned LO = field_lo(i, MOD_A, MOD_B, MOD_C, MOD_D);

      p_digit_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid |-> (int'(y_res[LO +: LW]) < int'(LM)));

      p_lane_add_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && opcode == 2'b00) |=>
            (int'(y_res[LO +: LW]) ==
             (int'($past(a_res[LO +: LW])) + int'($past(b_res[LO +: LW]))) % int'(LM)));

      p_lane_sub_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && opcode == 2'b01) |=>
            ((int'(y_res[LO +: LW]) + int'($past(b_res[LO +: LW]))) % int'(LM) ==
             int'($past(a_res[LO +: LW]))));

      p_lane_mul_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && opcode == 2'b10) |=>
            (int'(y_res[LO +: LW]) ==
             (int'($past(a_res[LO +: LW])) * int'($past(b_res[LO +: LW]))) % int'(LM)));
   end
endmodule

bind rns_alu rns_alu_chk #(
   .MOD_A(MOD_A), .MOD_B(MOD_B), .MOD_C(MOD_C), .MOD_D(MOD_D)
) u_rns_alu_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
   .a_res(a_res), .b_res(b_res), .out_valid(out_valid), .y_res(y_res)
);

// File: tb/rns_alu_bench.sv
`timescale 1ns/1ps
module rns_alu_bench;
   import rns_pkg::*;

   localparam int unsigned MA = 5, MB = 7, MC = 9, MD = 4;
   localparam int unsigned RW = digit_width(MA) + digit_width(MB) + digit_width(MC) + digit_width(MD);
   localparam int unsigned BW = 16;
   localparam int RANGE = MA * MB * MC * MD;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [1:0]    opcode = 2'b00;
   logic [RW-1:0] a_res = '0;
   logic [RW-1:0] b_res = '0;
   logic          out_valid;
   logic [RW-1:0] y_res;
   logic [BW-1:0] conv_in = '0;
   logic [RW-1:0] conv_out;

   always #2 clk = ~clk;

   rns_alu u_rns_alu (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
      .a_res(a_res), .b_res(b_res), .out_valid(out_valid), .y_res(y_res)
   );

   rns_bin2res #(.BW(BW)) u_conv (.bin_val(conv_in), .res_val(conv_out));

   typedef struct {
      logic [RW-1:0] y;
      string         tag;
   } exp_t;

   exp_t sb[$];
   int total = 0;
   int bad = 0;
   bit finished = 0;

   function automatic int lane_m(int i);
      return int'(pick_mod(i, MA, MB, MC, MD));
   endfunction

   function automatic int lane_lo(int i);
      return int'(field_lo(i, MA, MB, MC, MD));
   endfunction

   function automatic int get_digit(logic [RW-1:0] v, int i);
      int w;
      w = int'(digit_width(pick_mod(i, MA, MB, MC, MD)));
      return int'((v >> lane_lo(i)) & ((RW'(1) << w) - 1));
   endfunction

   // R1 layout, built from an integer
   function automatic logic [RW-1:0] to_res(int v);
      logic [RW-1:0] r;
      int vv;
      r = '0;
      vv = ((v % RANGE) + RANGE) % RANGE;
      for (int i = 0; i < 4; i++) r |= RW'(vv % lane_m(i)) << lane_lo(i);
      return r;
   endfunction

   function automatic logic [RW-1:0] exp_vec(logic [1:0] op, logic [RW-1:0] a, logic [RW-1:0] b);
      logic [RW-1:0] r;
      int x, y, m, d;
      r = '0;
      for (int i = 0; i < 4; i++) begin
         m = lane_m(i);
         x = get_digit(a, i);
         y = get_digit(b, i);
         case (op)
            2'b00:   d = (x + y) % m;
            2'b01:   d = (x - y + m) % m;
            default: d = (x * y) % m;
         endcase
         r |= RW'(d) << lane_lo(i);
      end
      return r;
   endfunction

   task automatic check(bit ok, string tag, logic [RW-1:0] act, logic [RW-1:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%03h expected=%03h", tag, act, exp);
      end
   endtask

   // driver: leaves in_valid high, call idle() to drop it
   task automatic issue(logic [1:0] op, logic [RW-1:0] a, logic [RW-1:0] b, string tag);
      exp_t e;
      @(negedge clk);
      in_valid = 1'b1;
      opcode   = op;
      a_res    = a;
      b_res    = b;
      if (op != 2'b11) begin
         e.y = exp_vec(op, a, b);
         e.tag = tag;
         sb.push_back(e);
      end
   endtask

   task automatic issue_int(logic [1:0] op, int a, int b, string tag);
      int r;
      exp_t e;
      @(negedge clk);
      in_valid = 1'b1;
      opcode   = op;
      a_res    = to_res(a);
      b_res    = to_res(b);
      case (op)
         2'b00:   r = a + b;
         2'b01:   r = a - b;
         default: r = a * b;
      endcase
      e.y = to_res(r);
      e.tag = tag;
      sb.push_back(e);
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = 1'b0;
      opcode   = 2'b00;
   endtask

   // monitor: pops expected items as results emerge
   always @(negedge clk) begin
      if (rst_n && out_valid && !finished) begin
         if (sb.size() == 0) begin
            check(1'b0, "R6 unexpected out_valid", y_res, '0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            check(y_res == e.y, e.tag, y_res, e.y);
            for (int i = 0; i < 4; i++)
               check(get_digit(y_res, i) < lane_m(i), "R9 digit range", y_res, e.y);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [RW-1:0] snap;
      logic [RW-1:0] base_a;
      logic [RW-1:0] base_b;

      // R8 reset state
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R8 out_valid in reset", RW'(out_valid), '0);
      check(y_res == '0, "R8 y_res in reset", y_res, '0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0, "R8 out_valid after reset", RW'(out_valid), '0);

      // R10 worked examples and R1 layout
      issue_int(2'b00, 29, 27, "R10 29+27");
      issue_int(2'b10, 10, 17, "R10 10*17");
      issue_int(2'b01, 10, 17, "R10 10-17");
      idle();
      @(negedge clk);
      check(to_res(56) == RW'({2'd0, 4'd2, 3'd0, 3'd1}), "R1 layout of 56", to_res(56),
            RW'({2'd0, 4'd2, 3'd0, 3'd1}));

      // R3 zero subtrahend digits (35 is 0 mod 5 and 0 mod 7, 36 is 0 mod 9 and 0 mod 4)
      issue_int(2'b01, 20, 35, "R3 sub zero digits");
      issue_int(2'b01, 7, 36, "R3 sub zero digits");
      issue_int(2'b01, 0, 0, "R3 sub all zero");
      issue_int(2'b01, 1259, 1259, "R3 sub equal");
      idle();

      // R10 wrap past the dynamic range
      issue_int(2'b00, 1000, 500, "R10 add wrap");
      issue_int(2'b10, 1259, 1259, "R10 mul wrap");
      issue_int(2'b10, 0, 777, "R4 mul by zero");
      idle();

      // R5 one lane changes at a time
      base_a = to_res(123);
      base_b = to_res(456);
      for (int i = 0; i < 4; i++) begin
         logic [RW-1:0] mod_a;
         int d;
         d = (get_digit(base_a, i) + 1) % lane_m(i);
         mod_a = base_a & ~(((RW'(1) << digit_width(pick_mod(i, MA, MB, MC, MD))) - 1) << lane_lo(i));
         mod_a |= RW'(d) << lane_lo(i);
         issue(2'b00, base_a, base_b, "R5 base add");
         issue(2'b00, mod_a, base_b, "R5 one-lane add");
         issue(2'b10, mod_a, base_b, "R5 one-lane mul");
         issue(2'b01, mod_a, base_b, "R5 one-lane sub");
      end
      idle();
      @(negedge clk);

      // R7 reserved opcode holds the result and raises no valid
      issue_int(2'b00, 300, 400, "R7 setup");
      issue(2'b11, to_res(5), to_res(6), "R7 reserved");
      snap = y_res;
      idle();
      check(out_valid == 1'b0, "R7 no out_valid", RW'(out_valid), '0);
      check(y_res == snap, "R7 y_res held", y_res, snap);
      @(negedge clk);
      check(y_res == snap, "R7 y_res held idle", y_res, snap);

      // R2 R3 R4 R6 back-to-back sweep
      for (int n = 0; n < 300; n++) begin
         int x, y;
         x = int'($urandom_range(0, RANGE - 1));
         y = int'($urandom_range(0, RANGE - 1));
         case (n % 3)
            0: issue_int(2'b00, x, y, "R2 add sweep");
            1: issue_int(2'b01, x, y, "R3 sub sweep");
            default: issue_int(2'b10, x, y, "R4 mul sweep");
         endcase
         if (n % 17 == 0) idle();
      end
      idle();
      @(negedge clk);
      @(negedge clk);
      check(sb.size() == 0, "R6 all results delivered", RW'(sb.size()), '0);

      // R11 helper conversion
      for (int k = 0; k < 8; k++) begin
         int v;
         case (k)
            0: v = 0;
            1: v = 56;
            2: v = 1259;
            3: v = 1260;
            4: v = 1261;
            5: v = 65535;
            6: v = 4097;
            default: v = 170;
         endcase
         conv_in = BW'(v);
         #1;
         check(conv_out == to_res(v), "R11 helper conversion", conv_out, to_res(v));
      end

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule